// File: doc/BRIEF.md
# Fault Latch and Alert Controller

This block keeps the fault bookkeeping of a power-switch supervisor. It holds three registers: a live status register that follows the condition inputs, a sticky fault register, and an alert-mask register. A fault bit is latched when its condition appears. An active-low alert line is pulled for each newly latched fault whose mask bit is set. The alert is released when the device wins an alert-response-address exchange or when the bus master addresses the device directly.

Fault bits are cleared in several ways. Software can write zeros to the fault register. A falling switch-on control, an undervoltage reset or a supply lockout clears the whole register. A falling board-present input clears most bits and records the change in bit 4. A fault whose condition is still present is never cleared. The block also decides whether the power switch may turn on. Without autoretry, the sticky fault bits decide this. With autoretry, the live status decides it.

Bit map, used in both the status and the fault registers:

| Bit | Meaning |
|-----|---------|
| 0–2 | Switch-holding conditions (`condIn[2:0]`) |
| 3 | Power-bad |
| 4 | Board-present (status) or board-change (fault) |
| 5 | Auxiliary condition |

The serial bus, the comparators and the gate drive lie outside the block. All bus events arrive as single-cycle pulses.

Top module: `fault_alert_top`

## Requirements
- R1: After reset the mask register is zero, so no fault drives the alert. `alertN` is low exactly when some fault bit is pending and its mask bit (same bit position) is set.
- R2: Power-bad status bit 3 equals `fbLow & gateOn`. When it is set, fault bit 3 latches. While `gateOn` is low, `fbLow` has no effect. Status bit 3 clears by itself when `fbLow` drops, and fault bit 3 stays set.
- R3: An alert is raised once per rising edge of a fault bit. After a release, a persistent fault does not re-raise the alert. A different bit setting does re-raise it. The same bit being cleared and then set again also re-raises it.
- R4: On `araPulse`, while the alert is asserted, the device wins if `rivalValid` is low or `devAddr < rivalAddr`. A win pulses `araWin` for one cycle and releases the alert. A loss leaves the alert asserted. An `araPulse` while the alert is idle gives no win.
- R5: An `addrHit` pulse releases the alert.
- R6: A fault write keeps only the bits where `faultWrData` is 1. A written zero does not clear a bit whose status bit 0–3 or 5 is still set.
- R7: The whole fault register clears, and its pending alerts drop, on any of these events: `onCtl` falling, `uvReset` high, or `supplyLockout` high.
- R8: When `boardPresent` falls, fault bits 0–3 and 5 clear and fault bit 4 sets.
- R9: `swEnable` requires `onCtl`. With `autoRetry` low, any of fault bits 0–2 holds it off. With `autoRetry` high, only status bits 0–2 hold it off, and the fault bits are left unchanged.
- R10: Reset state: faults zero, status bit 4 equal to `boardPresent` (all other status bits 0 when the conditions are idle), mask zero, `alertN` high, `araWin` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| condIn | input | 3 | Switch-holding fault conditions (status/fault bits 0–2) |
| auxCond | input | 1 | Auxiliary fault condition (bit 5) |
| fbLow | input | 1 | Feedback below power-good threshold |
| gateOn | input | 1 | Gate-to-source drive high enough to qualify power-bad |
| boardPresent | input | 1 | Board-present level |
| onCtl | input | 1 | Switch-on control |
| uvReset | input | 1 | Undervoltage reset |
| supplyLockout | input | 1 | Internal supply lockout |
| autoRetry | input | 1 | Autoretry mode select |
| faultWrEn | input | 1 | Fault register write strobe |
| faultWrData | input | 6 | Fault write data (0 clears a bit) |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | 6 | Mask write data |
| araPulse | input | 1 | Alert-response-address broadcast seen |
| rivalValid | input | 1 | Another responder contends |
| rivalAddr | input | ADDR_W | Contending responder address |
| devAddr | input | ADDR_W | This device's bus address |
| addrHit | input | 1 | Device addressed directly by the master |
| faultOut | output | 6 | Sticky fault register |
| statusOut | output | 6 | Live status register |
| maskOut | output | 6 | Alert mask register |
| alertN | output | 1 | Alert, active low (1 means released) |
| araWin | output | 1 | Pulse: won the alert-response exchange |
| swEnable | output | 1 | Switch may be on |

## Verification
The bench builds the block with the default 7-bit address width. This is wide enough to place a rival address both below and above `devAddr`, so both outcomes of the arbitration can be checked.

The six-bit register layout is fixed. With it, every clearing path can be exercised against the bits it must spare:
- a written zero, a falling switch-on control, undervoltage and lockout;
- the board-present edge that clears most bits but sets bit 4.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
  localparam int NUM_FAULT = 6;
  localparam int NUM_HOLD  = 3;
  localparam int IDX_PBAD  = 3;
  localparam int IDX_BDCHG = 4;
  localparam logic [NUM_FAULT-1:0] BDCHG_BIT    = NUM_FAULT'(1) << IDX_BDCHG;
  localparam logic [NUM_FAULT-1:0] PRESENT_MASK = ~BDCHG_BIT;

  typedef struct packed {
    logic clrAll;
    logic bdFall;
    logic faultWr;
    logic maskWr;
    logic relAlert;
  } strobe_t;
endpackage

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
  import fault_alert_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              onCtl,
  input  logic              boardPresent,
  input  logic              uvReset,
  input  logic              supplyLockout,
  input  logic              faultWrEn,
  input  logic              maskWrEn,
  input  logic              araPulse,
  input  logic              rivalValid,
  input  logic [ADDR_W-1:0] rivalAddr,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              addrHit,
  input  logic              alertActive,
  output strobe_t           stb,
  output logic              araWin
);
  logic onPrev;
  logic bpPrev;
  logic winNow;

  // Edge history; reset to 0 so no false falling edge appears after reset.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      onPrev <= 1'b0;
      bpPrev <= 1'b0;
      araWin <= 1'b0;
    end else begin
      onPrev <= onCtl;
      bpPrev <= boardPresent;
      araWin <= winNow;
    end
  end

  // Arbitration: lower address wins; only an alerting device responds.
  always_comb begin
    winNow = araPulse && alertActive && (!rivalValid || (devAddr < rivalAddr));
  end

  always_comb begin
    stb.clrAll   = (onPrev && !onCtl) || uvReset || supplyLockout;
    stb.bdFall   = bpPrev && !boardPresent;
    stb.faultWr  = faultWrEn;
    stb.maskWr   = maskWrEn;
    stb.relAlert = winNow || addrHit;
  end
endmodule

// File: rtl/fault_alert_dp.sv
module fault_alert_dp
  import fault_alert_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [NUM_HOLD-1:0]  condIn,
  input  logic                 auxCond,
  input  logic                 fbLow,
  input  logic                 gateOn,
  input  logic                 boardPresent,
  input  logic                 onCtl,
  input  logic                 autoRetry,
  input  logic [NUM_FAULT-1:0] faultWrData,
  input  logic [NUM_FAULT-1:0] maskWrData,
  output logic [NUM_FAULT-1:0] statusQ,
  output logic [NUM_FAULT-1:0] faultQ,
  output logic [NUM_FAULT-1:0] maskQ,
  output logic                 alertActive,
  output logic                 alertN,
  output logic                 swEnable
);
  logic [NUM_FAULT-1:0] statusD;
  logic [NUM_FAULT-1:0] keepVec;
  logic [NUM_FAULT-1:0] setVec;
  logic [NUM_FAULT-1:0] faultD;
  logic [NUM_FAULT-1:0] riseVec;
  logic [NUM_FAULT-1:0] pendQ;

  // Live conditions; power-bad qualified by the gate drive level.
  always_comb begin
    statusD = {auxCond, boardPresent, fbLow & gateOn, condIn};
  end

  // Combine the clearing rules into one keep mask.
  always_comb begin
    keepVec = '1;
    if (stb.clrAll)  keepVec = '0;
    if (stb.bdFall)  keepVec &= BDCHG_BIT;
    if (stb.faultWr) keepVec &= faultWrData;
  end

  // Present conditions always re-set their bit, so they cannot be cleared.
  always_comb begin
    setVec  = (statusQ & PRESENT_MASK) | (stb.bdFall ? BDCHG_BIT : '0);
    faultD  = (faultQ & keepVec) | setVec;
    riseVec = faultD & ~faultQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      faultQ  <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusD;
      faultQ  <= faultD;
      if (stb.maskWr) maskQ <= maskWrData;
    end
  end

  // One pending flag per fault bit: armed by a rising fault edge,
  // dropped on release or when the fault bit itself clears.
  for (genvar i = 0; i < NUM_FAULT; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[i] <= 1'b0;
      end else if (stb.relAlert) begin
        pendQ[i] <= riseVec[i];
      end else begin
        pendQ[i] <= (pendQ[i] | riseVec[i]) & faultD[i];
      end
    end
  end

  always_comb begin
    alertActive = |(pendQ & maskQ);
    alertN      = !alertActive;
  end

  // Switch permission: sticky faults without autoretry, live status with it.
  always_comb begin
    if (autoRetry) swEnable = onCtl && !(|statusQ[NUM_HOLD-1:0]);
    else           swEnable = onCtl && !(|faultQ[NUM_HOLD-1:0]);
  end
endmodule

// File: rtl/fault_alert_top.sv
module fault_alert_top
  import fault_alert_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_HOLD-1:0]  condIn,
  input  logic                 auxCond,
  input  logic                 fbLow,
  input  logic                 gateOn,
  input  logic                 boardPresent,
  input  logic                 onCtl,
  input  logic                 uvReset,
  input  logic                 supplyLockout,
  input  logic                 autoRetry,
  input  logic                 faultWrEn,
  input  logic [NUM_FAULT-1:0] faultWrData,
  input  logic                 maskWrEn,
  input  logic [NUM_FAULT-1:0] maskWrData,
  input  logic                 araPulse,
  input  logic                 rivalValid,
  input  logic [ADDR_W-1:0]    rivalAddr,
  input  logic [ADDR_W-1:0]    devAddr,
  input  logic                 addrHit,
  output logic [NUM_FAULT-1:0] faultOut,
  output logic [NUM_FAULT-1:0] statusOut,
  output logic [NUM_FAULT-1:0] maskOut,
  output logic                 alertN,
  output logic                 araWin,
  output logic                 swEnable
);
  strobe_t stb;
  logic    alertActive;

  fault_alert_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .onCtl(onCtl), .boardPresent(boardPresent),
    .uvReset(uvReset), .supplyLockout(supplyLockout), .faultWrEn(faultWrEn),
    .maskWrEn(maskWrEn), .araPulse(araPulse), .rivalValid(rivalValid),
    .rivalAddr(rivalAddr), .devAddr(devAddr), .addrHit(addrHit),
    .alertActive(alertActive), .stb(stb), .araWin(araWin)
  );

  fault_alert_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .condIn(condIn), .auxCond(auxCond),
    .fbLow(fbLow), .gateOn(gateOn), .boardPresent(boardPresent), .onCtl(onCtl),
    .autoRetry(autoRetry), .faultWrData(faultWrData), .maskWrData(maskWrData),
    .statusQ(statusOut), .faultQ(faultOut), .maskQ(maskOut),
    .alertActive(alertActive), .alertN(alertN), .swEnable(swEnable)
  );
endmodule

// File: rtl/fault_alert_chk.sv
module fault_alert_chk
  import fault_alert_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_FAULT-1:0] faultOut,
  input logic [NUM_FAULT-1:0] statusOut,
  input logic [NUM_FAULT-1:0] maskOut,
  input logic                 alertN,
  input logic                 araWin,
  input logic                 swEnable,
  input logic                 autoRetry,
  input strobe_t              stb
);
  // R1: nothing enabled means the alert stays released
  a_r1_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (maskOut == '0) |-> alertN);

  // R6: a present condition survives any clearing in the next cycle
  a_r6_present_kept: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((faultOut & $past(statusOut & PRESENT_MASK)) == $past(statusOut & PRESENT_MASK)));

  // R9: sticky hold-off faults without autoretry block the switch
  a_r9_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    (!autoRetry && (|faultOut[NUM_HOLD-1:0])) |-> !swEnable);

  // R4: a win is only reported for an alert that was asserted
  a_r4_win_needs_alert: assert property (@(posedge clk) disable iff (!rstN)
    araWin |-> !$past(alertN));

  // R8: a board-present fall records the change flag
  a_r8_board_flag: assert property (@(posedge clk) disable iff (!rstN)
    stb.bdFall |=> faultOut[IDX_BDCHG]);
endmodule

bind fault_alert_top fault_alert_chk chk_i (
  .clk(clk), .rstN(rstN), .faultOut(faultOut), .statusOut(statusOut),
  .maskOut(maskOut), .alertN(alertN), .araWin(araWin), .swEnable(swEnable),
  .autoRetry(autoRetry), .stb(stb)
);

// File: tb/fault_alert_top_tb_top.sv
module fault_alert_top_tb_top;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] condIn = '0;
  logic auxCond = 0, fbLow = 0, gateOn = 0, boardPresent = 1, onCtl = 1;
  logic uvReset = 0, supplyLockout = 0, autoRetry = 0;
  logic faultWrEn = 0, maskWrEn = 0;
  logic [5:0] faultWrData = '0, maskWrData = '0;
  logic araPulse = 0, rivalValid = 0, addrHit = 0;
  logic [AW-1:0] rivalAddr = '0, devAddr = 7'h2A;
  logic [5:0] faultOut, statusOut, maskOut;
  logic alertN, araWin, swEnable;

  int nRun = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  fault_alert_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .condIn(condIn), .auxCond(auxCond), .fbLow(fbLow),
    .gateOn(gateOn), .boardPresent(boardPresent), .onCtl(onCtl),
    .uvReset(uvReset), .supplyLockout(supplyLockout), .autoRetry(autoRetry),
    .faultWrEn(faultWrEn), .faultWrData(faultWrData), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .araPulse(araPulse), .rivalValid(rivalValid),
    .rivalAddr(rivalAddr), .devAddr(devAddr), .addrHit(addrHit),
    .faultOut(faultOut), .statusOut(statusOut), .maskOut(maskOut),
    .alertN(alertN), .araWin(araWin), .swEnable(swEnable)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeFault(input logic [5:0] d);
    faultWrEn = 1; faultWrData = d; step(1); faultWrEn = 0;
  endtask

  task automatic writeMask(input logic [5:0] d);
    maskWrEn = 1; maskWrData = d; step(1); maskWrEn = 0;
  endtask

  task automatic hitPulse();
    addrHit = 1; step(1); addrHit = 0;
  endtask

  task automatic t_reset();
    chk("R10 fault", faultOut, 0);
    chk("R10 status", statusOut, 6'b010000);
    chk("R10 mask", maskOut, 0);
    chk("R10 alertN", alertN, 1);
    chk("R10 araWin", araWin, 0);
  endtask

  task automatic t_mask();
    condIn[0] = 1; step(2);
    chk("R1 fault0 latched", faultOut[0], 1);
    chk("R1 masked no alert", alertN, 1);
    writeMask(6'b000001);
    chk("R1 enabled alert", alertN, 0);
    hitPulse();
    chk("R5 direct release", alertN, 1);
    condIn[0] = 0; step(1);
    writeFault(6'b111110);
    chk("R6 write clears absent", faultOut, 0);
    writeMask(6'b111111);
  endtask

  task automatic t_power_bad();
    fbLow = 1; gateOn = 0; step(2);
    chk("R2 gate low ignored", {statusOut[3], faultOut[3]}, 0);
    gateOn = 1; step(2);
    chk("R2 status set", statusOut[3], 1);
    chk("R2 fault set", faultOut[3], 1);
    chk("R2 alert", alertN, 0);
    fbLow = 0; step(1);
    chk("R2 status self clears", statusOut[3], 0);
    chk("R2 fault sticky", faultOut[3], 1);
    hitPulse(); writeFault(6'b110111); gateOn = 0;
    chk("R2 cleaned", {faultOut, alertN}, 7'b0000001);
  endtask

  task automatic t_once();
    condIn[1] = 1; step(2);
    chk("R3 first alert", alertN, 0);
    hitPulse(); step(3);
    chk("R3 persistent no realert", alertN, 1);
    condIn[2] = 1; step(2);
    chk("R3 other bit realerts", alertN, 0);
    hitPulse();
    condIn[1] = 0; step(1);
    writeFault(6'b111101);
    chk("R3 bit1 cleared", faultOut[1], 0);
    chk("R3 no alert after clear", alertN, 1);
    condIn[1] = 1; step(2);
    chk("R3 same bit again", alertN, 0);
    condIn = '0; step(1); writeFault(0);
    chk("R7 cleanup", alertN, 1);
  endtask

  task automatic t_ara();
    condIn[0] = 1; step(2);
    rivalValid = 1; rivalAddr = 7'h10; araPulse = 1; step(1); araPulse = 0;
    chk("R4 lose araWin", araWin, 0);
    chk("R4 lose keeps alert", alertN, 0);
    rivalAddr = 7'h50; araPulse = 1; step(1); araPulse = 0;
    chk("R4 win araWin", araWin, 1);
    chk("R4 win releases", alertN, 1);
    step(1);
    chk("R4 win single pulse", araWin, 0);
    rivalValid = 0; araPulse = 1; step(1); araPulse = 0;
    chk("R4 idle no win", araWin, 0);
    condIn = '0; step(1); writeFault(0);
  endtask

  task automatic t_write_present();
    condIn[0] = 1; step(2);
    writeFault(0);
    chk("R6 present not cleared", faultOut[0], 1);
    condIn[0] = 0; step(1);
    writeFault(0);
    chk("R6 cleared when absent", faultOut[0], 0);
  endtask

  task automatic setPulse2();
    condIn[2] = 1; step(2); condIn[2] = 0; step(1);
  endtask

  task automatic t_clear_all();
    setPulse2();
    chk("R7 preset", faultOut[2], 1);
    onCtl = 0; step(1);
    chk("R7 on fall clears", {faultOut, alertN}, 7'b0000001);
    onCtl = 1; step(1);
    setPulse2();
    uvReset = 1; step(1); uvReset = 0;
    chk("R7 uv clears", faultOut, 0);
    setPulse2();
    supplyLockout = 1; step(1); supplyLockout = 0;
    chk("R7 lockout clears", faultOut, 0);
  endtask

  task automatic t_board();
    condIn = 3'b111; auxCond = 1; fbLow = 1; gateOn = 1; step(2);
    condIn = '0; auxCond = 0; fbLow = 0; gateOn = 0; step(1);
    chk("R8 preset", faultOut, 6'b101111);
    boardPresent = 0; step(1);
    chk("R8 board fall", faultOut, 6'b010000);
    hitPulse();
    boardPresent = 1; step(1);
    writeFault(0);
  endtask

  task automatic t_switch();
    autoRetry = 0; onCtl = 1;
    chk("R9 idle enabled", swEnable, 1);
    condIn[0] = 1; step(2);
    chk("R9 fault holds off", swEnable, 0);
    condIn[0] = 0; step(1);
    chk("R9 sticky holds off", swEnable, 0);
    autoRetry = 1; #1;
    chk("R9 autoretry ignores faults", swEnable, 1);
    chk("R9 fault kept", faultOut[0], 1);
    condIn[1] = 1; step(1);
    chk("R9 status holds autoretry", swEnable, 0);
    condIn[1] = 0; step(1); autoRetry = 0;
    writeFault(0); hitPulse();
    chk("R9 cleared enables", swEnable, 1);
    onCtl = 0; #1;
    chk("R9 needs onCtl", swEnable, 0);
    onCtl = 1; step(1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    step(3); rstN = 1; step(1);
    t_reset();
    t_mask();
    t_power_bad();
    t_once();
    t_ara();
    t_write_present();
    t_clear_all();
    t_board();
    t_switch();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule